// File: doc/BRIEF.md
# USB Endpoint Interrupt Flag Unit

This block keeps the interrupt flags, the interrupt enables and the buffer-error status for every endpoint of a small USB device controller. The CPU sees them through one byte-wide register window. An endpoint-select register decides which endpoint's flags, enables and error status appear in that window. Transaction logic reports events as a set of flag bits tagged with an endpoint number. The data buffers report buffer overflow and underflow, and they also report each endpoint's fill state.

Firmware clears a flag by writing zero to it. Writing one never sets a flag. When firmware acknowledges a received setup packet, the block also marks the endpoint ready to transmit and drops any pending OUT-received flag. The read/write-allowed bit is not stored. Each read computes it from the selected endpoint's direction and buffer fill state. The block keeps one summary bit per endpoint that shows which endpoints have pending events. A single level request line combines every enabled flag across all endpoints.

Top module: `usb_ep_irq_unit`

## Requirements
- R1: After reset, every flag, enable, error status bit and summary bit is zero, the select register holds 0 and `ep_irq` is low.
- R2: An event with `ev_valid` high for endpoint `ev_ep` sets every flag bit that is 1 in `ev_flags`. The flag layout is: bit0 ready-to-transmit, bit1 stalled, bit2 OUT-received, bit3 setup-received, bit4 NAK-out, bit5 read/write-allowed, bit6 NAK-in, bit7 buffer-control. Bit 5 of `ev_flags` is ignored. An event whose endpoint number is 5 or more is ignored.
- R3: A CPU write to the flag register (offset 1) clears each flag that is written 0. A flag written 1 keeps its value, so a write never sets a flag.
- R4: When a flag write clears a set setup-received flag (bit3), the same write sets ready-to-transmit (bit0) and clears OUT-received (bit2).
- R5: Bit 5 of a flag-register read is computed on every read. It reads as "buffer not full" when the endpoint's direction is IN (`ep_dir_in`=1). It reads as "buffer not empty" when the direction is OUT. CPU writes to bit 5 have no effect.
- R6: Any event on an endpoint, whether a flag or an overflow/underflow, sets that endpoint's summary bit. The summary register is at offset 4, with endpoint n at bit n, and it also drives `ep_summary`. A flag write that leaves all flags except bit5 at zero clears the summary bit.
- R7: `ep_irq` is high exactly when `ctl_en` is 1 and some endpoint has a flag among bits 0-4 or bit 6 that is set while the enable bit at the same position is also set. The enable register is at offset 2. Bits 5 and 7 of the flags never request an interrupt.
- R8: Buffer overflow (`ev_ovf`) sets error-status bit 6 and buffer underflow (`ev_unf`) sets bit 5. The error-status register is at offset 3. Either bit requests an interrupt only while enable bit 7 is set.
- R9: Writing zero to error-status bit 6 or bit 5 clears that bit. Writing one sets nothing. All other error-status bits read 0.
- R10: The select register is at offset 0. A write with a value of 0 to 4 selects that endpoint. A write with any larger value is ignored. Offsets 5 to 7 read 0.
- R11: When an event and a CPU flag clear hit the same endpoint in the same cycle, the event's flag bits and the summary bit end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 3 | Register offset |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data (combinational) |
| ev_valid | input | 1 | Event strobe |
| ev_ep | input | 3 | Endpoint targeted by the event |
| ev_flags | input | 8 | Flag bits to set |
| ev_ovf | input | 1 | Buffer overflow event |
| ev_unf | input | 1 | Buffer underflow event |
| buf_full | input | 5 | Per-endpoint buffer full |
| buf_empty | input | 5 | Per-endpoint buffer empty |
| ep_dir_in | input | 5 | Per-endpoint direction, 1 = IN |
| ctl_en | input | 1 | Global controller enable |
| ep_summary | output | 5 | Per-endpoint pending summary |
| ep_irq | output | 1 | Combined endpoint interrupt request |

## Verification
Some properties are checked on every cycle. A flag write without a concurrent event never raises a flag. A setup-received acknowledge yields ready-to-transmit set and OUT-received clear. Every event sets its endpoint's summary bit. An overflow event always lands in the error status. The select register never leaves the legal range, and the request line stays low while the controller is disabled. Only the directed scenarios can show other behaviour: the exact read values through the select window, the live read/write-allowed bit under changing fill and direction, the masking of bits 5 and 7, the ignored out-of-range writes and events, and the priority of an event over a clear in the same cycle.

// File: rtl/usbepi_pkg.sv
package usbepi_pkg;

   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      OFS_SEL  = 3'd0,
      OFS_FLAG = 3'd1,
      OFS_IEN  = 3'd2,
      OFS_ERR  = 3'd3,
      OFS_SUM  = 3'd4
   } reg_ofs_e;

   // flag byte positions
   localparam int F_TXRDY  = 0;
   localparam int F_STALL  = 1;
   localparam int F_OUTRX  = 2;
   localparam int F_SETUP  = 3;
   localparam int F_NAKOUT = 4;
   localparam int F_RWOK   = 5;
   localparam int F_NAKIN  = 6;
   localparam int F_BUFCTL = 7;

   // error status / enable positions
   localparam int E_UNF    = 5;
   localparam int E_OVF    = 6;
   localparam int E_FLOWEN = 7;

   localparam logic [7:0] IRQ_FLAG_MASK = 8'h5F;
   localparam logic [7:0] SUM_HOLD_MASK = 8'hDF;
   localparam logic [7:0] STORE_MASK    = 8'hDF;

endpackage

// File: rtl/epi_flag_bank.sv
module epi_flag_bank
   import usbepi_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       cpu_sel,
   input  logic       wr_flag,
   input  logic       wr_ien,
   input  logic       wr_err,
   input  logic [7:0] wdata,
   input  logic       ev_hit,
   input  logic [7:0] ev_flags,
   input  logic       ev_ovf,
   input  logic       ev_unf,
   input  logic       buf_full,
   input  logic       buf_empty,
   input  logic       dir_in,
   output logic [7:0] flag_view,
   output logic [7:0] ien_view,
   output logic [7:0] err_view,
   output logic       sum_q,
   output logic       req
);

   logic [7:0] flags_q, ien_q;
   logic       ovf_q, unf_q;
   logic [7:0] flag_clr, ev_set, flag_nxt;
   logic       ev_any, sum_nxt, ovf_nxt, unf_nxt, rw_ok;

   always_comb begin
      flag_clr = flags_q;
      if (cpu_sel && wr_flag) begin
         flag_clr = flags_q & wdata;
         if (flags_q[F_SETUP] && !wdata[F_SETUP]) begin
            flag_clr[F_TXRDY] = 1'b1;
            flag_clr[F_OUTRX] = 1'b0;
         end
      end
      flag_clr = flag_clr & STORE_MASK;
      ev_set   = ev_hit ? (ev_flags & STORE_MASK) : 8'h00;
      flag_nxt = flag_clr | ev_set;
      ev_any   = ev_hit && ((|ev_set) || ev_ovf || ev_unf);

      sum_nxt = sum_q;
      if (cpu_sel && wr_flag && ((flag_clr & SUM_HOLD_MASK) == 8'h00))
         sum_nxt = 1'b0;
      if (ev_any)
         sum_nxt = 1'b1;

      ovf_nxt = ovf_q;
      unf_nxt = unf_q;
      if (cpu_sel && wr_err) begin
         ovf_nxt = ovf_q & wdata[E_OVF];
         unf_nxt = unf_q & wdata[E_UNF];
      end
      if (ev_hit && ev_ovf) ovf_nxt = 1'b1;
      if (ev_hit && ev_unf) unf_nxt = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         flags_q <= '0;
         ien_q   <= '0;
         ovf_q   <= 1'b0;
         unf_q   <= 1'b0;
         sum_q   <= 1'b0;
      end else begin
         flags_q <= flag_nxt;
         ovf_q   <= ovf_nxt;
         unf_q   <= unf_nxt;
         sum_q   <= sum_nxt;
         if (cpu_sel && wr_ien)
            ien_q <= wdata;
      end
   end

   assign rw_ok = dir_in ? !buf_full : !buf_empty;

   always_comb begin
      flag_view         = flags_q;
      flag_view[F_RWOK] = rw_ok;
      ien_view          = ien_q;
      err_view          = '0;
      err_view[E_OVF]   = ovf_q;
      err_view[E_UNF]   = unf_q;
   end

   assign req = (|(flags_q & ien_q & IRQ_FLAG_MASK)) ||
                ((ovf_q || unf_q) && ien_q[E_FLOWEN]);

   a_r3_write_never_sets: assert property (@(posedge clk) disable iff (rst)
      (cpu_sel && wr_flag && !ev_hit && !flags_q[F_SETUP])
      |=> ((flags_q & ~$past(flags_q)) == 8'h00));

   a_r4_setup_ack: assert property (@(posedge clk) disable iff (rst)
      (cpu_sel && wr_flag && !ev_hit && flags_q[F_SETUP] && !wdata[F_SETUP])
      |=> (flags_q[F_TXRDY] && !flags_q[F_OUTRX] && !flags_q[F_SETUP]));

   a_r6_summary_on_event: assert property (@(posedge clk) disable iff (rst)
      ev_any |=> sum_q);

   a_r8_ovf_latched: assert property (@(posedge clk) disable iff (rst)
      (ev_hit && ev_ovf) |=> ovf_q);

endmodule

// File: rtl/epi_irq_merge.sv
module epi_irq_merge #(
   parameter int NUM_EP  = 5,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_EP-1:0] req_vec,
   input  logic              glb_en,
   output logic              irq
);

   logic any_req;
   assign any_req = glb_en && (|req_vec);

   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (rst) irq_q <= 1'b0;
            else     irq_q <= any_req;
         end
         assign irq = irq_q;

         a_r7_gate_q: assert property (@(posedge clk) disable iff (rst)
            !glb_en |=> !irq);
      end else begin : g_comb
         assign irq = any_req;

         a_r7_gate: assert property (@(posedge clk) disable iff (rst)
            !glb_en |-> !irq);
      end
   endgenerate

endmodule

// File: rtl/usb_ep_irq_unit.sv
module usb_ep_irq_unit
   import usbepi_pkg::*;
#(
   parameter int NUM_EP  = 5,
   parameter bit IRQ_REG = 1'b0,
   localparam int EPW    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [REG_AW-1:0] cpu_addr,
   input  logic              cpu_wr,
   input  logic [7:0]        cpu_wdata,
   output logic [7:0]        cpu_rdata,
   input  logic              ev_valid,
   input  logic [EPW-1:0]    ev_ep,
   input  logic [7:0]        ev_flags,
   input  logic              ev_ovf,
   input  logic              ev_unf,
   input  logic [NUM_EP-1:0] buf_full,
   input  logic [NUM_EP-1:0] buf_empty,
   input  logic [NUM_EP-1:0] ep_dir_in,
   input  logic              ctl_en,
   output logic [NUM_EP-1:0] ep_summary,
   output logic              ep_irq
);

   generate
      if (NUM_EP < 1 || NUM_EP > 8) begin : g_bad_ep
         $error("usb_ep_irq_unit: NUM_EP must lie in 1..8");
      end
   endgenerate

   logic [EPW-1:0]    sel_q;
   logic              wr_flag, wr_ien, wr_err, wr_sel;
   logic [7:0]        flag_v [NUM_EP];
   logic [7:0]        ien_v  [NUM_EP];
   logic [7:0]        err_v  [NUM_EP];
   logic [NUM_EP-1:0] sum_vec, req_vec;

   assign wr_sel  = cpu_wr && (cpu_addr == OFS_SEL);
   assign wr_flag = cpu_wr && (cpu_addr == OFS_FLAG);
   assign wr_ien  = cpu_wr && (cpu_addr == OFS_IEN);
   assign wr_err  = cpu_wr && (cpu_addr == OFS_ERR);

   always_ff @(posedge clk) begin
      if (rst)
         sel_q <= '0;
      else if (wr_sel && (cpu_wdata < 8'(NUM_EP)))
         sel_q <= cpu_wdata[EPW-1:0];
   end

   generate
      for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
         logic hit;
         assign hit = ev_valid && (ev_ep == EPW'(i));
         epi_flag_bank u_bank (
            .clk       (clk),
            .rst       (rst),
            .cpu_sel   (sel_q == EPW'(i)),
            .wr_flag   (wr_flag),
            .wr_ien    (wr_ien),
            .wr_err    (wr_err),
            .wdata     (cpu_wdata),
            .ev_hit    (hit),
            .ev_flags  (ev_flags),
            .ev_ovf    (ev_ovf),
            .ev_unf    (ev_unf),
            .buf_full  (buf_full[i]),
            .buf_empty (buf_empty[i]),
            .dir_in    (ep_dir_in[i]),
            .flag_view (flag_v[i]),
            .ien_view  (ien_v[i]),
            .err_view  (err_v[i]),
            .sum_q     (sum_vec[i]),
            .req       (req_vec[i])
         );
      end
   endgenerate

   always_comb begin
      cpu_rdata = '0;
      case (cpu_addr)
         OFS_SEL:  cpu_rdata[EPW-1:0] = sel_q;
         OFS_SUM:  cpu_rdata[NUM_EP-1:0] = sum_vec;
         OFS_FLAG: for (int i = 0; i < NUM_EP; i++)
                      if (sel_q == EPW'(i)) cpu_rdata = flag_v[i];
         OFS_IEN:  for (int i = 0; i < NUM_EP; i++)
                      if (sel_q == EPW'(i)) cpu_rdata = ien_v[i];
         OFS_ERR:  for (int i = 0; i < NUM_EP; i++)
                      if (sel_q == EPW'(i)) cpu_rdata = err_v[i];
         default:  cpu_rdata = '0;
      endcase
   end

   assign ep_summary = sum_vec;

   epi_irq_merge #(.NUM_EP(NUM_EP), .IRQ_REG(IRQ_REG)) u_merge (
      .clk     (clk),
      .rst     (rst),
      .req_vec (req_vec),
      .glb_en  (ctl_en),
      .irq     (ep_irq)
   );

   a_r10_sel_range: assert property (@(posedge clk) disable iff (rst)
      32'(sel_q) < NUM_EP);

endmodule

// File: tb/sim_usb_ep_irq_unit.sv
module sim_usb_ep_irq_unit;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] cpu_addr = '0;
   logic       cpu_wr = 1'b0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic       ev_valid = 1'b0;
   logic [2:0] ev_ep = '0;
   logic [7:0] ev_flags = '0;
   logic       ev_ovf = 1'b0;
   logic       ev_unf = 1'b0;
   logic [4:0] buf_full = 5'b00000;
   logic [4:0] buf_empty = 5'b11111;
   logic [4:0] ep_dir_in = 5'b00000;
   logic       ctl_en = 1'b0;
   logic [4:0] ep_summary;
   logic       ep_irq;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   usb_ep_irq_unit u0 (
      .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ev_valid(ev_valid),
      .ev_ep(ev_ep), .ev_flags(ev_flags), .ev_ovf(ev_ovf), .ev_unf(ev_unf),
      .buf_full(buf_full), .buf_empty(buf_empty), .ep_dir_in(ep_dir_in),
      .ctl_en(ctl_en), .ep_summary(ep_summary), .ep_irq(ep_irq)
   );

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic rd_check(input string tag, input logic [2:0] a, input logic [7:0] exp);
      cpu_addr = a;
      #1;
      check(tag, cpu_rdata, exp);
   endtask

   task automatic event_in(input logic [2:0] ep, input logic [7:0] f,
                           input logic o, input logic u);
      @(negedge clk);
      ev_valid = 1'b1; ev_ep = ep; ev_flags = f; ev_ovf = o; ev_unf = u;
      @(negedge clk);
      ev_valid = 1'b0; ev_flags = '0; ev_ovf = 1'b0; ev_unf = 1'b0;
   endtask

   task automatic t_reset();
      for (int a = 0; a < 5; a++) rd_check("R1 reset reg", 3'(a), 8'h00);
      check("R1 reset summary", 8'(ep_summary), 8'h00);
      check("R1 reset irq", 8'(ep_irq), 8'h00);
   endtask

   task automatic t_event_set();
      event_in(3'd2, 8'hFF, 1'b0, 1'b0);
      wr(3'd0, 8'd2);
      rd_check("R2 event sets flags, bit5 ignored", 3'd1, 8'hDF);
      check("R6 summary after event", 8'(ep_summary), 8'h04);
      event_in(3'd5, 8'hFF, 1'b1, 1'b1);
      check("R2 out-of-range event ignored", 8'(ep_summary), 8'h04);
   endtask

   task automatic t_clear();
      wr(3'd1, 8'hFE);
      rd_check("R3 clear bit0", 3'd1, 8'hDE);
      wr(3'd1, 8'hFF);
      rd_check("R3 write ones sets nothing", 3'd1, 8'hDE);
      wr(3'd1, 8'hF7);
      rd_check("R4 setup ack", 3'd1, 8'hD3);
      check("R6 summary held while flags left", 8'(ep_summary), 8'h04);
      wr(3'd1, 8'h20);
      rd_check("R3 clear all", 3'd1, 8'h00);
      check("R6 summary cleared", 8'(ep_summary), 8'h00);
   endtask

   task automatic t_rwok();
      buf_empty[2] = 1'b0;
      rd_check("R5 OUT not empty", 3'd1, 8'h20);
      ep_dir_in[2] = 1'b1; buf_full[2] = 1'b1;
      rd_check("R5 IN full", 3'd1, 8'h00);
      buf_full[2] = 1'b0;
      rd_check("R5 IN not full", 3'd1, 8'h20);
      wr(3'd1, 8'h20);
      ep_dir_in[2] = 1'b0; buf_empty[2] = 1'b1;
      rd_check("R5 write to bit5 ignored", 3'd1, 8'h00);
   endtask

   task automatic t_irq();
      wr(3'd0, 8'd1);
      wr(3'd2, 8'h04);
      ctl_en = 1'b1;
      event_in(3'd1, 8'h02, 1'b0, 1'b0);
      check("R7 unenabled flag no irq", 8'(ep_irq), 8'h00);
      event_in(3'd1, 8'h04, 1'b0, 1'b0);
      check("R7 enabled flag irq", 8'(ep_irq), 8'h01);
      ctl_en = 1'b0; #1;
      check("R7 global gate", 8'(ep_irq), 8'h00);
      ctl_en = 1'b1;
      wr(3'd1, 8'hFB);
      check("R7 irq drops on clear", 8'(ep_irq), 8'h00);
      wr(3'd2, 8'hA0);
      event_in(3'd1, 8'h80, 1'b0, 1'b0);
      check("R7 bit7 and bit5 never request", 8'(ep_irq), 8'h00);
      rd_check("R7 flags ep1", 3'd1, 8'h82);
   endtask

   task automatic t_flow();
      wr(3'd0, 8'd3);
      event_in(3'd3, 8'h00, 1'b1, 1'b0);
      rd_check("R8 overflow status", 3'd3, 8'h40);
      check("R8 no irq without flow enable", 8'(ep_irq), 8'h00);
      wr(3'd2, 8'h80);
      check("R8 irq with flow enable", 8'(ep_irq), 8'h01);
      wr(3'd3, 8'hFF);
      rd_check("R9 write ones keeps", 3'd3, 8'h40);
      wr(3'd3, 8'h00);
      rd_check("R9 write zero clears", 3'd3, 8'h00);
      check("R8 irq gone", 8'(ep_irq), 8'h00);
      event_in(3'd3, 8'h00, 1'b0, 1'b1);
      rd_check("R8 underflow status", 3'd3, 8'h20);
      check("R6 summary from error events", 8'(ep_summary), 8'h0A);
   endtask

   task automatic t_select();
      wr(3'd0, 8'd5);
      rd_check("R10 select 5 ignored", 3'd0, 8'h03);
      wr(3'd0, 8'hFF);
      rd_check("R10 select FF ignored", 3'd0, 8'h03);
      wr(3'd0, 8'd4);
      rd_check("R10 select 4", 3'd0, 8'h04);
      rd_check("R10 offset 6 reads 0", 3'd6, 8'h00);
      wr(3'd0, 8'd0);
      rd_check("R10 select 0", 3'd0, 8'h00);
   endtask

   task automatic t_collide();
      event_in(3'd0, 8'h10, 1'b0, 1'b0);
      @(negedge clk);
      cpu_addr = 3'd1; cpu_wdata = 8'hEF; cpu_wr = 1'b1;
      ev_valid = 1'b1; ev_ep = 3'd0; ev_flags = 8'h10;
      @(negedge clk);
      cpu_wr = 1'b0; ev_valid = 1'b0; ev_flags = '0;
      rd_check("R11 event beats clear", 3'd1, 8'h10);
      check("R11 summary kept", 8'(ep_summary & 5'h01), 8'h01);
   endtask

   initial begin
      #800000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_event_set();
      t_clear();
      t_rwok();
      t_irq();
      t_flow();
      t_select();
      t_collide();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule